// File: doc/BRIEF.md
# Transmit Byte Register with Preamble Fill

This block sits between a serial host-command decoder and a modulator. It holds the bytes to be sent in two stages. A shift stage drives the modulator one bit per bit-clock tick, most significant bit first. A holding stage takes the next byte from the host. Each byte arrives as a one-cycle write strobe with the byte value. The strobe comes from the serial register-write command, after the decoder upstream has taken it apart.

When the block is reset, and whenever the enable is low, both stages are loaded with the alternating pattern 8'hAA. A transmitter that the host never feeds therefore sends a 1/0 preamble. If the shift stage empties and no byte is waiting, the pattern is sent again. The transmitter never stalls.

A registered ready flag drives the host's serial data-out line. It is high while the block is enabled and the holding stage is free. Two sticky flags record lost writes and preamble refills. Both clear when the enable drops.

Top module: `txbyte_preamble`

## Requirements
- R1: After a synchronous reset, `tx_bit` is 1 (the MSB of 8'hAA) and `sdo_rdy`, `ovr_flag` and `unr_flag` are 0.
- R2: With no host writes, the enabled block sends a repeating 1,0,1,0 pattern, one bit per tick.
- R3: Bits leave MSB first. `tx_bit` advances only on a cycle with `bit_tick` high and holds its value otherwise.
- R4: A byte that was accepted while another byte was shifting is sent whole, right after that byte's last bit.
- R5: `sdo_rdy` is 1 exactly when the block is enabled and the holding stage is free. It drops after the clock edge that accepts a write, the same edge that fills the stage.
- R6: A write that arrives while the holding stage is full, and no byte is finishing, is ignored and sets the sticky `ovr_flag`. The byte being shifted and the waiting byte are kept.
- R7: If a byte finishes and no byte is waiting, 8'hAA is sent next and the sticky `unr_flag` is set.
- R8: While `tx_en` is 0, both stages hold 8'hAA and any waiting byte is discarded. Ticks and writes have no effect, `sdo_rdy` is 0, and both sticky flags are cleared.
- R9: A write on the same cycle that the last bit finishes is accepted even when the holding stage was full. The waiting byte moves to the shift stage, the new byte takes its place, and `ovr_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit register enable; low reloads the preamble |
| wr_stb | input | 1 | One-cycle strobe for a host byte write |
| wr_byte | input | W | Byte written by the host |
| bit_tick | input | 1 | One-cycle transmit bit-clock tick |
| tx_bit | output | 1 | Serial bit to the modulator |
| sdo_rdy | output | 1 | Ready for the next byte (drives host data-out) |
| ovr_flag | output | 1 | Sticky flag: a write was lost |
| unr_flag | output | 1 | Sticky flag: the preamble refilled an empty shift stage |

## Verification
The end of a byte and a host write can fall on the same cycle. The holding stage then empties and fills on one edge. To provoke this, the bench ticks on every cycle, keeps the holding stage full, and strobes a write exactly when its model shows the final bit with a tick pending. It also runs long random mixes of ticks and writes. The bench judges the outcome at the ports: `ovr_flag` must stay low, `sdo_rdy` must stay low, and both the waiting byte and the new byte must come out on `tx_bit` in order.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  typedef enum logic {
    HOLD_EMPTY  = 1'b0,
    HOLD_LOADED = 1'b1
  } hold_st_e;
endpackage

// File: rtl/tbr_hold.sv
module tbr_hold
  import tbr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] FILL = 8'hAA
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_byte,
  input  logic         take,
  output logic [W-1:0] hold_q,
  output logic         full_q,
  output logic         full_d,
  output logic         drop
);
  hold_st_e st_q, st_d;
  logic [W-1:0] data_d;
  logic accept;

  assign accept = en && wr_stb && ((st_q == HOLD_EMPTY) || take);
  assign drop   = en && wr_stb && !accept;

  always_comb begin
    st_d   = st_q;
    data_d = hold_q;
    if (!en) begin
      st_d   = HOLD_EMPTY;
      data_d = FILL;
    end else if (accept) begin
      st_d   = HOLD_LOADED;
      data_d = wr_byte;
    end else if (take) begin
      st_d   = HOLD_EMPTY;
      data_d = FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= HOLD_EMPTY;
      hold_q <= FILL;
    end else begin
      st_q   <= st_d;
      hold_q <= data_d;
    end
  end

  assign full_q = (st_q == HOLD_LOADED);
  assign full_d = (st_d == HOLD_LOADED);

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (rst)
    accept |=> full_q && (hold_q == $past(wr_byte))); // R5
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    drop |=> $stable(hold_q) && full_q); // R6
endmodule

// File: rtl/tbr_shift.sv
module tbr_shift #(
  parameter int W = 8,
  parameter logic [W-1:0] FILL = 8'hAA
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] hold_q,
  input  logic         hold_full,
  output logic         take,
  output logic         starve,
  output logic         tx_bit
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  assign take   = en && tick && (cnt_q == '0);
  assign starve = take && !hold_full;
  assign tx_bit = sh_q[W-1];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh_q  <= FILL;
      cnt_q <= LAST;
    end else if (take) begin
      sh_q  <= hold_q;
      cnt_q <= LAST;
    end else if (tick) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_DISABLED_FILL: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sh_q == FILL)); // R8
  AST_STARVE_FILLS: assert property (@(posedge clk) disable iff (rst)
    starve |=> (sh_q == FILL)); // R7
  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(tx_bit)); // R3
endmodule

// File: rtl/tbr_flags.sv
module tbr_flags (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic full_q,
  input  logic full_d,
  input  logic drop,
  input  logic starve,
  output logic rdy_q,
  output logic ovr_q,
  output logic unr_q
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      unr_q <= 1'b0;
    end else begin
      rdy_q <= !full_d;
      ovr_q <= ovr_q || drop;
      unr_q <= unr_q || starve;
    end
  end

  AST_RDY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> !full_q); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && en) |=> ovr_q); // R6
  AST_UNR_ON_STARVE: assert property (@(posedge clk) disable iff (rst)
    starve |=> unr_q); // R7
endmodule

// File: rtl/txbyte_preamble.sv
module txbyte_preamble #(
  parameter int W = 8,
  parameter logic [W-1:0] FILL = 8'hAA
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_en,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_byte,
  input  logic         bit_tick,
  output logic         tx_bit,
  output logic         sdo_rdy,
  output logic         ovr_flag,
  output logic         unr_flag
);
  logic [W-1:0] hold_q;
  logic full_q, full_d, drop, take, starve;

  tbr_hold #(.W(W), .FILL(FILL)) u_hold (
    .clk(clk), .rst(rst), .en(tx_en), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .take(take), .hold_q(hold_q), .full_q(full_q), .full_d(full_d),
    .drop(drop)
  );

  tbr_shift #(.W(W), .FILL(FILL)) u_shift (
    .clk(clk), .rst(rst), .en(tx_en), .tick(bit_tick), .hold_q(hold_q),
    .hold_full(full_q), .take(take), .starve(starve), .tx_bit(tx_bit)
  );

  tbr_flags u_flags (
    .clk(clk), .rst(rst), .en(tx_en), .full_q(full_q), .full_d(full_d),
    .drop(drop), .starve(starve), .rdy_q(sdo_rdy), .ovr_q(ovr_flag),
    .unr_q(unr_flag)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (tx_en && wr_stb && sdo_rdy) |=> !ovr_flag || $past(ovr_flag)); // R6
endmodule

// File: tb/sim_txbyte_preamble.sv
module sim_txbyte_preamble;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic bit_tick = 1'b0;
  logic tx_bit, sdo_rdy, ovr_flag, unr_flag;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [7:0] m_cur = 8'hAA;
  int m_pos = 7;
  logic [7:0] m_pend[$];
  bit m_rdy = 0, m_ovr = 0, m_unr = 0;
  bit model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txbyte_preamble u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .bit_tick(bit_tick), .tx_bit(tx_bit), .sdo_rdy(sdo_rdy),
    .ovr_flag(ovr_flag), .unr_flag(unr_flag)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst || !tx_en) begin
      m_cur = 8'hAA; m_pos = 7; m_pend.delete();
      m_rdy = 0; m_ovr = 0; m_unr = 0;
    end else begin
      bit take, acc;
      take = bit_tick && (m_pos == 0);
      acc  = (m_pend.size() == 0) || take;
      if (take) begin
        if (m_pend.size() > 0) m_cur = m_pend.pop_front();
        else begin m_cur = 8'hAA; m_unr = 1; end
        m_pos = 7;
      end else if (bit_tick) m_pos--;
      if (wr_stb) begin
        if (acc) m_pend.push_back(wr_byte);
        else m_ovr = 1;
      end
      m_rdy = (m_pend.size() == 0);
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R3 tx_bit vs model", tx_bit, m_cur[m_pos]);
      check("R5 sdo_rdy vs model", sdo_rdy, m_rdy);
      check("R6 ovr_flag vs model", ovr_flag, m_ovr);
      check("R7 unr_flag vs model", unr_flag, m_unr);
    end
  end

  task automatic cyc(bit en, bit t, bit w, logic [7:0] d);
    @(negedge clk);
    #1;
    tx_en = en; bit_tick = t; wr_stb = w; wr_byte = d;
  endtask

  initial begin
    repeat (3) cyc(0, 0, 0, 8'h00);
    rst = 1'b1;
    cyc(1, 0, 0, 8'h00);
    @(negedge clk);
    check("R1 tx_bit reset", tx_bit, 1'b1);
    check("R1 sdo_rdy reset", sdo_rdy, 1'b0);
    check("R1 ovr_flag reset", ovr_flag, 1'b0);
    check("R1 unr_flag reset", unr_flag, 1'b0);
    #1 rst = 1'b0;
    model_on = 1;

    // R2: preamble with no writes, tick every third cycle
    begin
      logic prev;
      cyc(1, 0, 0, 8'h00);
      cyc(1, 0, 0, 8'h00);
      prev = tx_bit;
      for (int i = 0; i < 20; i++) begin
        cyc(1, 1, 0, 8'h00);
        cyc(1, 0, 0, 8'h00);
        cyc(1, 0, 0, 8'h00);
        check("R2 preamble alternates", tx_bit, ~prev);
        prev = tx_bit;
      end
    end
    check("R5 ready when empty", sdo_rdy, 1'b1);

    // R4/R6: fill holding stage, then overrun attempt
    cyc(1, 0, 1, 8'h3C);
    cyc(1, 0, 1, 8'hFF);
    cyc(1, 0, 0, 8'h00);
    check("R5 ready drops on fill", sdo_rdy, 1'b0);
    check("R6 overrun flagged", ovr_flag, 1'b1);
    for (int i = 0; i < 40; i++) cyc(1, 1, 0, 8'h00);

    // R9: coincident write at byte end with holding stage full
    cyc(1, 0, 1, 8'h81);
    cyc(1, 0, 0, 8'h00);
    cyc(0, 0, 0, 8'h00);
    cyc(1, 0, 0, 8'h00);
    check("R8 ovr cleared by disable", ovr_flag, 1'b0);
    cyc(1, 0, 1, 8'hC3);
    cyc(1, 0, 0, 8'h00);
    begin
      int guard = 0;
      while (!(m_pos == 0) && guard < 20) begin
        cyc(1, 1, 0, 8'h00);
        guard++;
      end
      // model now at last bit with waiting byte: tick and write together
      cyc(1, 1, 1, 8'h5A);
      cyc(1, 0, 0, 8'h00);
      cyc(1, 0, 0, 8'h00);
      check("R9 coincident write not overrun", ovr_flag, 1'b0);
      check("R9 stage still full", sdo_rdy, 1'b0);
      check("R9 first bit of waiting byte", tx_bit, 1'b1);
      for (int i = 0; i < 20; i++) cyc(1, 1, 0, 8'h00);
    end

    // R8: disable mid-byte with pending data, ticks and writes ignored
    cyc(1, 0, 1, 8'h0F);
    cyc(1, 1, 0, 8'h00);
    cyc(0, 1, 1, 8'h00);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 8'h00);
    cyc(0, 0, 0, 8'h00);
    check("R8 disabled tx_bit fill MSB", tx_bit, 1'b1);
    check("R8 disabled not ready", sdo_rdy, 1'b0);
    check("R8 disabled unr cleared", unr_flag, 1'b0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r != 0, ($urandom_range(0, 2) == 0), ($urandom_range(0, 9) == 0),
          8'($urandom));
    end
    cyc(1, 0, 0, 8'h00);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule